// File: doc/BRIEF.md
# Byte-fed inner-product parity engine

The engine returns the binary inner product of a 512-bit challenge and a 512-bit secret key as a single parity bit. Both operands enter one byte per clock, each through its own shift-register deserializer. A deserializer counts as full only after 64 byte beats have arrived since reset or since the previous accepted load.

When a load strobe arrives with both deserializers full and no computation running, the engine ANDs the two words bit by bit and keeps the product. It then reduces the product in eight serial steps. Each step passes one 64-bit slice through a six-level parallel XOR tree and folds the tree output into a one-bit accumulator. After the last step the parity output updates and a one-cycle valid pulse is issued. The parity output then keeps its value until the next result.

Top module: `parity_engine`

## Requirements
- R1: A synchronous reset clears both deserializers, their fill counts, the serial accumulator, the busy flag, the parity output and the valid flag. After reset `busy`, `parity` and `parity_valid` read 0, and a load issued before any byte beat is ignored.
- R2: The parity result equals the XOR over all 512 bits of the bitwise AND of key and challenge, which is the count of positions where both are 1, taken modulo 2.
- R3: The byte presented on beat j (0 to 63) of the most recent 64 beats occupies bits 8j+7 down to 8j of its word, with the LSB of the byte at bit 8j. Key and challenge bytes given on the same beat are therefore paired bit for bit.
- R4: A load is accepted only when at least 64 byte beats have been shifted in since reset or since the last accepted load. With 63 beats the load is ignored: no valid pulse follows.
- R5: `parity_valid` rises exactly 8 clock edges after the edge that accepts a load, and it stays high for exactly one cycle.
- R6: While a computation runs, further loads and byte beats do not change its result and do not produce extra valid pulses.
- R7: `busy` is high from the edge that accepts a load until the edge that raises `parity_valid`, where it falls.
- R8: `parity` keeps its value in every cycle where `parity_valid` is low.
- R9: A reset asserted during a computation aborts it. No valid pulse follows, and `parity` reads 0.
- R10: When more than 64 beats arrive before a load, only the most recent 64 beats form the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Byte beat: both input bytes are shifted in on this edge |
| key_byte | input | 8 | Key byte stream |
| chal_byte | input | 8 | Challenge byte stream |
| load | input | 1 | Load/compute strobe |
| busy | output | 1 | Serial reduction in progress |
| parity | output | 1 | Last computed inner-product parity |
| parity_valid | output | 1 | One-cycle pulse when parity is new |

## Verification
A byte beat or load presented before a rising edge takes effect at that edge. `busy` is high right after the accepting edge, and the parity with its valid pulse appears 8 edges later. The bench drives every input on falling edges and samples on falling edges. After each accepted load it checks busy at the first falling edge, checks that valid is still low at the seventh, and checks parity, valid and busy at the eighth. At the ninth it checks that the pulse has ended. Ignored loads are checked by counting valid pulses over a window longer than a full reduction.

// File: rtl/parity_engine_pkg.sv
package parity_engine_pkg;

  typedef enum logic {
    FOLD_IDLE = 1'b0,
    FOLD_RUN  = 1'b1
  } fold_state_e;

  // number of beats or slices needed to cover a word
  function automatic int unsigned span_count(input int unsigned total, input int unsigned part);
    return total / part;
  endfunction

  // one node of the reduction tree
  function automatic logic pair_xor(input logic a, input logic b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/byte_deser.sv
module byte_deser #(
  parameter int unsigned WORD_W = 512,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [BUS_W-1:0]  din,
  input  logic              clear_fill,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  import parity_engine_pkg::*;

  localparam int unsigned BEATS = span_count(WORD_W, BUS_W);
  localparam int unsigned CNT_W = $clog2(BEATS + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  fill_cnt;
  logic              at_cap;

  assign at_cap = (fill_cnt == CNT_W'(BEATS));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      fill_cnt <= '0;
    end else begin
      if (shift_en)
        shreg <= {din, shreg[WORD_W-1:BUS_W]};
      if (clear_fill)
        fill_cnt <= shift_en ? CNT_W'(1) : '0;
      else if (shift_en && !at_cap)
        fill_cnt <= fill_cnt + CNT_W'(1);
    end
  end

  assign word = shreg;
  assign full = at_cap;

  // R4
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(BEATS));

  // R4
  fill_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_fill |=> !full);

endmodule

// File: rtl/xor_tree.sv
module xor_tree #(
  parameter int unsigned LANES = 64
) (
  input  logic [LANES-1:0] din,
  output logic             dout
);
  import parity_engine_pkg::*;

  localparam int unsigned LEVELS = $clog2(LANES);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned N = LANES >> l;
    logic [N-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = din;
    end else begin : g_node
      always_comb begin
        for (int i = 0; i < int'(N); i++)
          v[i] = pair_xor(g_lvl[l-1].v[2*i], g_lvl[l-1].v[2*i+1]);
      end
    end
  end

  assign dout = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/serial_fold.sv
module serial_fold #(
  parameter int unsigned WORD_W = 512,
  parameter int unsigned PAR_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  output logic              busy,
  output logic              parity,
  output logic              valid
);
  import parity_engine_pkg::*;

  localparam int unsigned STEPS  = span_count(WORD_W, PAR_W);
  localparam int unsigned STEP_W = $clog2(STEPS + 1);

  fold_state_e       state;
  logic [WORD_W-1:0] prod;
  logic [STEP_W-1:0] step;
  logic              acc;
  logic              lane_par;
  logic              last_step;

  xor_tree #(.LANES(PAR_W)) i_tree (
    .din  (prod[PAR_W-1:0]),
    .dout (lane_par)
  );

  assign last_step = (step == STEP_W'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FOLD_IDLE;
      prod   <= '0;
      step   <= '0;
      acc    <= 1'b0;
      parity <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        FOLD_IDLE: begin
          if (start) begin
            prod  <= word_in;
            step  <= '0;
            acc   <= 1'b0;
            state <= FOLD_RUN;
          end
        end
        FOLD_RUN: begin
          prod <= prod >> PAR_W;
          step <= step + STEP_W'(1);
          if (last_step) begin
            parity <= pair_xor(acc, lane_par);
            valid  <= 1'b1;
            state  <= FOLD_IDLE;
          end else begin
            acc <= pair_xor(acc, lane_par);
          end
        end
        default: state <= FOLD_IDLE;
      endcase
    end
  end

  assign busy = (state == FOLD_RUN);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && last_step) |=> (valid && !busy));

  // R7
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || valid));

  // R8
  parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(parity));

endmodule

// File: rtl/parity_engine.sv
module parity_engine #(
  parameter int unsigned WORD_W = 512,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned PAR_W  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [BUS_W-1:0] key_byte,
  input  logic [BUS_W-1:0] chal_byte,
  input  logic             load,
  output logic             busy,
  output logic             parity,
  output logic             parity_valid
);

  logic [WORD_W-1:0] key_word;
  logic [WORD_W-1:0] chal_word;
  logic [WORD_W-1:0] and_word;
  logic              key_full;
  logic              chal_full;
  logic              accept;

  byte_deser #(.WORD_W(WORD_W), .BUS_W(BUS_W)) i_key_deser (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .din        (key_byte),
    .clear_fill (accept),
    .word       (key_word),
    .full       (key_full)
  );

  byte_deser #(.WORD_W(WORD_W), .BUS_W(BUS_W)) i_chal_deser (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .din        (chal_byte),
    .clear_fill (accept),
    .word       (chal_word),
    .full       (chal_full)
  );

  assign accept   = load && key_full && chal_full && !busy;
  assign and_word = key_word & chal_word;

  serial_fold #(.WORD_W(WORD_W), .PAR_W(PAR_W)) i_fold (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .word_in (and_word),
    .busy    (busy),
    .parity  (parity),
    .valid   (parity_valid)
  );

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(load));

  // R4
  rise_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(key_full && chal_full));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !parity_valid && !parity));

endmodule

// File: tb/test_parity_engine.sv
module test_parity_engine;

  localparam int W     = 512;
  localparam int BW    = 8;
  localparam int BEATS = W / BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shift_en = 1'b0;
  logic [BW-1:0] key_byte = '0;
  logic [BW-1:0] chal_byte = '0;
  logic          load = 1'b0;
  logic          busy;
  logic          parity;
  logic          parity_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  parity_engine i_parity_engine (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (shift_en),
    .key_byte     (key_byte),
    .chal_byte    (chal_byte),
    .load         (load),
    .busy         (busy),
    .parity       (parity),
    .parity_valid (parity_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_parity(input logic [W-1:0] k, input logic [W-1:0] c);
    int n = 0;
    for (int i = 0; i < W; i++)
      if (k[i] === 1'b1 && c[i] === 1'b1) n++;
    return n % 2;
  endfunction

  task automatic rand_word(output logic [W-1:0] w);
    for (int i = 0; i < W / 32; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      w[32*i +: 32] = rng;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; shift_en = 1'b0; load = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_beats(input logic [W-1:0] k, input logic [W-1:0] c,
                            input int first, input int count);
    for (int j = first; j < first + count; j++) begin
      @(negedge clk);
      shift_en  = 1'b1;
      key_byte  = k[BW*j +: BW];
      chal_byte = c[BW*j +: BW];
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  // returns at the falling edge after the edge that samples load
  task automatic pulse_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (parity_valid) n++;
    end
  endtask

  task automatic expect_result(input string req, input int exp);
    check({"R7 busy after accept / ", req}, busy, 1);
    repeat (7) @(negedge clk);
    check("R5 valid not early", parity_valid, 0);
    check("R7 busy during fold", busy, 1);
    @(negedge clk);
    check("R5 valid on eighth edge", parity_valid, 1);
    check(req, parity, exp);
    check("R7 busy falls with valid", busy, 0);
    @(negedge clk);
    check("R5 valid one cycle", parity_valid, 0);
  endtask

  task automatic run_query(input string req, input logic [W-1:0] k, input logic [W-1:0] c);
    send_beats(k, c, 0, BEATS);
    pulse_load();
    expect_result(req, ref_parity(k, c));
  endtask

  task automatic t_reset_state();
    int n;
    check("R1 busy after reset", busy, 0);
    check("R1 valid after reset", parity_valid, 0);
    check("R1 parity after reset", parity, 0);
    pulse_load();
    count_pulses(12, n);
    check("R1 load on empty deserializers ignored", n, 0);
  endtask

  task automatic t_patterns();
    logic [W-1:0] k, c;
    run_query("R2 all zero", '0, '0);
    run_query("R2 all ones even count", '1, '1);
    k = '1; c = '0; c[77] = 1'b1;
    run_query("R2 single overlap", k, c);
    for (int r = 0; r < 5; r++) begin
      rand_word(k); rand_word(c);
      run_query("R2 random query", k, c);
    end
  endtask

  task automatic t_alignment();
    logic [W-1:0] k, c;
    int pos[5] = '{0, 7, 8, 300, 511};
    foreach (pos[i]) begin
      k = '0; c = '0; k[pos[i]] = 1'b1; c[pos[i]] = 1'b1;
      run_query("R3 same bit paired", k, c);
    end
    k = '0; c = '0; k[16] = 1'b1; c[24] = 1'b1;
    run_query("R3 next beat not paired", k, c);
  endtask

  task automatic t_partial_fill();
    logic [W-1:0] k, c;
    int n;
    k = '0; c = '0; k[5] = 1'b1; c[5] = 1'b1;
    send_beats(k, c, 0, BEATS - 1);
    pulse_load();
    count_pulses(12, n);
    check("R4 load after 63 beats ignored", n, 0);
    send_beats(k, c, BEATS - 1, 1);
    pulse_load();
    expect_result("R4 load after 64th beat", 1);
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] k, c, k2;
    int n;
    k = '0; c = '1; k[9] = 1'b1;
    k2 = '0;
    send_beats(k, c, 0, BEATS);
    pulse_load();
    load = 1'b1; shift_en = 1'b1; key_byte = 8'hFF; chal_byte = 8'hFF;
    repeat (3) @(negedge clk);
    load = 1'b0; shift_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 valid not early under extra loads", parity_valid, 0);
    @(negedge clk);
    check("R6 result unchanged by load/beats", parity, 1);
    check("R6 valid on time", parity_valid, 1);
    count_pulses(12, n);
    check("R6 no second pulse", n, 0);
    check("R8 parity held", parity, 1);
    send_beats(k2, k2, 0, 8);
    check("R8 parity held during shifting", parity, 1);
  endtask

  task automatic t_reset_abort();
    logic [W-1:0] k;
    int n;
    k = '0; k[100] = 1'b1;
    send_beats(k, k, 0, BEATS);
    pulse_load();
    repeat (2) @(negedge clk);
    do_reset();
    count_pulses(12, n);
    check("R9 no pulse after abort", n, 0);
    check("R9 parity cleared", parity, 0);
    check("R9 busy cleared", busy, 0);
  endtask

  task automatic t_overfill();
    logic [W-1:0] ka, kb;
    ka = '0; ka[3] = 1'b1;
    kb = '0; kb[3] = 1'b1; kb[4] = 1'b1;
    send_beats(ka, ka, 0, BEATS);
    send_beats(kb, kb, 0, BEATS);
    pulse_load();
    expect_result("R10 newest 64 beats used", 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_patterns();
    t_alignment();
    t_partial_fill();
    t_busy_ignore();
    t_reset_abort();
    t_overfill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule